// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a synchronous serial port from a faster module clock, together with two single-cycle strobes that tell a shift engine when the serial clock leaves and returns to its idle level. One configuration word picks between two divide laws. The linear law divides by twice an 8-bit count plus one, in steps of two. The power-of-two law divides by two raised to a 4-bit exponent, which reaches ratios far beyond the linear field. The output keeps a 50% duty cycle in both laws.

The shift engine holds `run` high for the length of a transfer. While `run` is low the counter is parked and the serial clock rests at the idle level given by `sclk_idle_hi`. The configuration is captured when a transfer starts and is held for its whole length, so a period is never cut short or stretched by a change made mid-transfer. Register decode and clock-domain crossing sit outside this block.

Top module: `sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: With `div_cfg[12]` = 1 (linear law), `sclk` changes level every N+1 module clocks, N = `div_cfg[7:0]`, for a period of 2×(N+1); `div_cfg[11:8]` has no effect.
- R3: With `div_cfg[12]` = 0 (power-of-two law) and M = `div_cfg[11:8]` ≥ 1, `sclk` changes level every 2^(M−1) module clocks, for a period of 2^M; `div_cfg[7:0]` has no effect.
- R4: In the power-of-two law, M = 0 gives the same output as M = 1: a change of level on every module clock.
- R5: While no transfer is running, `sclk` equals `sclk_idle_hi` as sampled on the previous clock edge.
- R6: `lead_stb` pulses for one cycle in exactly the cycle `sclk` first leaves the idle level of each period, `trail_stb` in exactly the cycle it returns; they are never high together, and `sclk` never changes during a transfer without one of them.
- R7: Changes to `div_cfg` or `sclk_idle_hi` while `run` is high do not affect the running transfer; they take effect at the next start.
- R8: After the edge that samples `run` low, `sclk` is at the idle level of the ended transfer and both strobes are 0; a new transfer starts a fresh count, its first change of level one full half-period after the edge that samples `run` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High for the length of a transfer |
| sclk_idle_hi | input | 1 | Idle level of the serial clock (1 = rests high) |
| div_cfg | input | 13 | [7:0] linear count N, [11:8] exponent M, [12] 1 = linear law, 0 = power-of-two law |
| sclk | output | 1 | Serial clock, registered |
| lead_stb | output | 1 | One-cycle pulse when `sclk` leaves the idle level |
| trail_stb | output | 1 | One-cycle pulse when `sclk` returns to the idle level |

## Verification
The bench builds the block with its default widths, an 8-bit linear count and a 4-bit exponent, so the shared half-period counter is 15 bits wide. That brings both ends of each law within reach: N = 0 and N = 255 in the linear law, and M = 0, 1 and the top exponent 15 (a half-period of 16384 clocks) in the power-of-two law, each followed cycle by cycle across at least one full period with both idle levels. Mid-transfer configuration changes, early stops and restarts are driven at the ports to show that no partial period or stale count leaks out.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

   // Divide law selected by the mode bit of the configuration word.
   typedef enum logic {
      DIV_POW2   = 1'b0,
      DIV_LINEAR = 1'b1
   } div_mode_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sclk_div_decode.sv
module sclk_div_decode
   import sclk_gen_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4,
   parameter int CNT_W = 15
) (
   input  div_mode_e          mode,
   input  logic [EXP_W-1:0]   expo,
   input  logic [LIN_W-1:0]   lin,
   output logic [CNT_W-1:0]   half
);

   localparam int N_EXP = 1 << EXP_W;

   // Elaboration checks on the widths.
   if (LIN_W < 1) begin : g_bad_lin
      $error("sclk_div_decode: LIN_W must be at least 1");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("sclk_div_decode: EXP_W must lie in 1..5");
   end
   if (CNT_W < LIN_W + 1 || CNT_W < N_EXP - 1) begin : g_bad_cnt
      $error("sclk_div_decode: CNT_W too narrow for the largest half-period");
   end

   // Half-period table for the power-of-two law, one entry per exponent.
   logic [CNT_W-1:0] pow_tab [N_EXP];

   for (genvar e = 0; e < N_EXP; e++) begin : g_exp
      if (e < 2) begin : g_fast
         // Exponent 0 is held at the fastest registered rate.
         assign pow_tab[e] = CNT_W'(1);
      end else begin : g_shift
         assign pow_tab[e] = CNT_W'(1) << (e - 1);
      end
   end

   logic [CNT_W-1:0] lin_half;
   assign lin_half = CNT_W'(lin) + CNT_W'(1);

   always_comb begin
      unique case (mode)
         DIV_LINEAR: half = lin_half;
         default:    half = pow_tab[expo];
      endcase
   end

endmodule

// File: rtl/sclk_div_counter.sv
module sclk_div_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] half,
   output logic             tick
);

   if (CNT_W < 2) begin : g_bad_w
      $error("sclk_div_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == half - CNT_W'(1));
   assign tick   = active & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q < half)) else $error("count passed half-period"); // R2

endmodule

// File: rtl/sclk_div_shaper.sv
module sclk_div_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic active,
   input  logic tick,
   input  logic idle_lvl,
   output logic sclk,
   output logic lead_stb,
   output logic trail_stb
);

   logic sclk_q, lead_q, trail_q;
   logic leaving_idle;

   assign leaving_idle = (sclk_q == idle_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else if (!run || !active) begin
         sclk_q  <= idle_lvl;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else if (tick) begin
         sclk_q  <= ~sclk_q;
         lead_q  <= leaving_idle;
         trail_q <= ~leaving_idle;
      end else begin
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end
   end

   assign sclk      = sclk_q;
   assign lead_stb  = lead_q;
   assign trail_stb = trail_q;

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_q && trail_q)) else $error("both strobes high"); // R6

   AST_LEAD_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lead_q |-> (sclk_q != idle_lvl)) else $error("lead strobe at idle level"); // R6

   AST_TOGGLE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
      ((sclk_q != $past(sclk_q)) && $past(run) && $past(active)) |-> (lead_q || trail_q))
      else $error("sclk moved without a strobe"); // R6

   AST_NO_STB_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!lead_q && !trail_q)) else $error("strobe while stopped"); // R8

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
   import sclk_gen_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4,
   localparam int CFG_W = LIN_W + EXP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sclk_idle_hi,
   input  logic [CFG_W-1:0] div_cfg,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);

   localparam int EXP_HALF_W = (1 << EXP_W) - 1;
   localparam int CNT_W      = max_int(LIN_W + 1, EXP_HALF_W);

   if (EXP_W > 5) begin : g_bad_exp
      $error("sclk_gen: EXP_W above 5 makes the counter too wide");
   end

   typedef struct packed {
      logic             idle_hi;
      logic             lin_sel;
      logic [EXP_W-1:0] expo;
      logic [LIN_W-1:0] lin;
   } cfg_t;

   cfg_t live_cfg, shadow_q, shadow_d;
   logic active_q;
   logic tick;
   logic idle_lvl;
   logic [CNT_W-1:0] half;

   assign live_cfg = {sclk_idle_hi, div_cfg};

   // The shadow follows the inputs while idle and is frozen while running.
   assign shadow_d = active_q ? shadow_q : live_cfg;
   assign idle_lvl = shadow_d.idle_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         shadow_q <= '0;
      end else begin
         active_q <= run;
         shadow_q <= shadow_d;
      end
   end

   sclk_div_decode #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .CNT_W (CNT_W)
   ) i_decode (
      .mode  (div_mode_e'(shadow_q.lin_sel)),
      .expo  (shadow_q.expo),
      .lin   (shadow_q.lin),
      .half  (half)
   );

   sclk_div_counter #(
      .CNT_W (CNT_W)
   ) i_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active_q),
      .half   (half),
      .tick   (tick)
   );

   sclk_div_shaper i_shaper (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .active    (active_q),
      .tick      (tick),
      .idle_lvl  (idle_lvl),
      .sclk      (sclk),
      .lead_stb  (lead_stb),
      .trail_stb (trail_stb)
   );

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (sclk == shadow_q.idle_hi)) else $error("sclk off idle level"); // R5

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> $stable(shadow_q)) else $error("config moved mid-run"); // R7

endmodule

// File: tb/test_sclk_gen.sv
module test_sclk_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        sclk_idle_hi = 1'b0;
   logic [12:0] div_cfg = '0;
   logic        sclk, lead_stb, trail_stb;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sclk_gen i_sclk_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .sclk_idle_hi (sclk_idle_hi),
      .div_cfg      (div_cfg),
      .sclk         (sclk),
      .lead_stb     (lead_stb),
      .trail_stb    (trail_stb)
   );

   task automatic chk(input int got, input int exp, input string what);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   function automatic logic [12:0] lin_cfg(input int n, input int junk_exp);
      return {1'b1, junk_exp[3:0], n[7:0]};
   endfunction

   function automatic logic [12:0] pow_cfg(input int m, input int junk_lin);
      return {1'b0, m[3:0], junk_lin[7:0]};
   endfunction

   // Half-period in module clocks, taken from the requirements.
   function automatic int half_of(input logic [12:0] c);
      int m;
      if (c[12]) return int'(c[7:0]) + 1;
      m = int'(c[11:8]);
      if (m == 0) return 1;
      return 1 << (m - 1);
   endfunction

   // One transfer of ncyc+1 clocks, checked every cycle.
   // At loop index chg_at the inputs are changed to alt values (R7).
   task automatic run_check(input logic [12:0] c, input logic idle, input int ncyc,
                            input int chg_at, input logic [12:0] c_alt,
                            input logic idle_alt, input string req);
      int h;
      int ph;
      h = half_of(c);
      @(negedge clk);
      div_cfg      = c;
      sclk_idle_hi = idle;
      @(negedge clk);
      chk(int'(sclk), int'(idle), {"R5 idle level before ", req});
      run = 1'b1;
      for (int k = 0; k <= ncyc; k++) begin
         @(posedge clk);
         @(negedge clk);
         ph = k / h;
         chk(int'(sclk), int'(idle ^ ph[0]), {req, " sclk"});
         chk(int'(lead_stb), int'(k > 0 && (k % h) == 0 && ph[0]), {"R6 lead in ", req});
         chk(int'(trail_stb), int'(k > 0 && (k % h) == 0 && !ph[0]), {"R6 trail in ", req});
         if (k == chg_at) begin
            div_cfg      = c_alt;
            sclk_idle_hi = idle_alt;
         end
      end
      run = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(int'(sclk), int'(idle), {"R8 idle after stop of ", req});
      chk(int'(lead_stb | trail_stb), 0, {"R8 strobes after stop of ", req});
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      sclk_idle_hi = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(int'(sclk), 0, "R1 sclk in reset");
         chk(int'(lead_stb | trail_stb), 0, "R1 strobes in reset");
      end
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(int'(sclk), 1, "R5 idle high after reset");
   endtask

   task automatic t_linear;
      run_check(lin_cfg(0, 4'hF), 1'b0, 8, -1, '0, 1'b0, "R2 N=0");
      run_check(lin_cfg(2, 4'h5), 1'b1, 20, -1, '0, 1'b0, "R2 N=2");
      run_check(lin_cfg(255, 4'hA), 1'b0, 1030, -1, '0, 1'b0, "R2 N=255");
   endtask

   task automatic t_pow2;
      run_check(pow_cfg(1, 8'h33), 1'b0, 9, -1, '0, 1'b0, "R3 M=1");
      run_check(pow_cfg(3, 8'hAB), 1'b1, 20, -1, '0, 1'b0, "R3 M=3");
      run_check(pow_cfg(15, 8'h00), 1'b0, 2 * 16384 + 2, -1, '0, 1'b0, "R3 M=15");
   endtask

   task automatic t_exp_zero;
      run_check(pow_cfg(0, 8'h77), 1'b1, 9, -1, '0, 1'b0, "R4 M=0");
   endtask

   task automatic t_change_mid_run;
      // Inputs switch to N=0 with idle high mid-run; the run keeps N=3, idle low.
      run_check(lin_cfg(3, 0), 1'b0, 24, 5, lin_cfg(0, 0), 1'b1, "R7 frozen N=3");
      // The next run picks up the new setting.
      run_check(lin_cfg(0, 0), 1'b1, 6, -1, '0, 1'b0, "R7 next run N=0");
   endtask

   task automatic t_restart;
      // Stop in the middle of a half-period, then restart with a fresh count.
      run_check(lin_cfg(4, 0), 1'b0, 7, -1, '0, 1'b0, "R8 early stop N=4");
      run_check(lin_cfg(4, 0), 1'b0, 22, -1, '0, 1'b0, "R8 restart N=4");
   endtask

   initial begin
      t_reset();
      t_linear();
      t_pow2();
      t_exp_zero();
      t_change_mid_run();
      t_restart();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule